// File: doc/BRIEF.md
# Transmit Highway Slot Multiplexer

This block assembles one transmit frame of 32 timeslots (256 bits) from two serial highway inputs: a payload data line and a signaling line. A sync pulse, together with a programmed bit offset, fixes where frame bit 0 falls on the highway. The highway clock may run at one, two, four or eight times the bit rate. In the over-clocked modes each bit cell is sampled exactly once, at its midpoint.

For every timeslot a 32-bit marker map chooses which input supplies that timeslot's bits. A global enable switches this per-slot choice on or off. When it is off, the whole frame comes from the data line.

When the last bit of a frame has been sampled, the block presents the complete frame on a wide parallel output and raises a one-cycle done strobe. The frame output then holds its value until the next frame completes. A transmit framer downstream consumes the frame on that strobe.

Top module: `txhw_slot_mux`

## Requirements
- R1: After reset `frame_out` is all zeros and `frame_done` is low. No frame is delivered, and no bit is sampled, until a sync event has been seen. A later reset returns the block to this state.
- R2: The sync line is active high when `sync_inv` is 0 and active low when it is 1. Only a change from inactive to active counts as a sync event, so holding the line active does not re-align the frame. The sync cycle is the first cycle of the bit cell that holds frame bit (256 − `bit_offset`) mod 256.
- R3: `rate_sel` values 0, 1, 2 and 3 give bit cells of 1, 2, 4 and 8 clock cycles.
- R4: Each bit cell is sampled once, in cycle index (cell length / 2) of the cell, counted from 0. In 1x mode this is the cell's only cycle.
- R5: When `mux_en` is 1 and `slot_map[i]` is 1, the bits of timeslot i are taken from `ser_sig`.
- R6: When `mux_en` is 1 and `slot_map[i]` is 0, the bits of timeslot i are taken from `ser_data`.
- R7: When `mux_en` is 0, every timeslot is taken from `ser_data`, whatever `slot_map` holds.
- R8: Frame bit p belongs to timeslot p/8 and is bit p mod 8 within it, and timeslots are sent MSB first. Timeslot i is placed in `frame_out[8i+7:8i]`, with its first received bit in position 8i+7.
- R9: `frame_done` is a one-cycle pulse in the cycle after frame bit 255 is sampled. `frame_out` takes the new frame on that same clock edge and is otherwise held.
- R10: A frame is delivered only if its bit 0 was sampled after the most recent sync event. A sync event in the middle of a frame discards the partly assembled frame.
- R11: `bit_offset` accepts every value from 0 to 255 bit cells, including both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Frame sync line |
| sync_inv | input | 1 | 1 makes the sync line active low |
| ser_data | input | 1 | Serial payload data input |
| ser_sig | input | 1 | Serial signaling input |
| rate_sel | input | 2 | Clocks per bit cell: 0=1, 1=2, 2=4, 3=8 |
| bit_offset | input | 8 | Frame start offset from sync, in bit cells |
| mux_en | input | 1 | Enables per-timeslot source selection |
| slot_map | input | 32 | Marker per timeslot; bit i is timeslot i |
| frame_out | output | 256 | Last assembled frame |
| frame_done | output | 1 | One-cycle strobe when a new frame is presented |

## Verification
A wrong phase counter, or a wrong choice of sample cycle, moves the `frame_done` strobe away from its computed cycle. The bench drives inverted values outside the midpoint cycle, so the same fault also corrupts frame bits. A wrong bit position or slot index puts bytes or bits in the wrong place in `frame_out`. A wrong alignment or start flag produces an extra strobe or a missing one. Every one of these faults is visible at the first `frame_done`, no more than one frame time (offset plus 256 bit cells) after the sync event.

// File: rtl/txhw_pkg.sv
// Shared types and helpers for the transmit highway slot multiplexer.
// Assumes at most eight highway clock cycles per bit cell.
package txhw_pkg;

    localparam int RATE_W  = 2;
    localparam int PHASE_W = 3;

    typedef enum logic [RATE_W-1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;

    // Index of the last cycle inside a bit cell.
    function automatic logic [PHASE_W-1:0] last_phase(input rate_e r);
        case (r)
            RATE_X1: return 3'd0;
            RATE_X2: return 3'd1;
            RATE_X4: return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // Index of the sampling cycle inside a bit cell (cell midpoint).
    function automatic logic [PHASE_W-1:0] mid_phase(input rate_e r);
        case (r)
            RATE_X1: return 3'd0;
            RATE_X2: return 3'd1;
            RATE_X4: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Length of a bit cell in clock cycles.
    function automatic logic [PHASE_W:0] cell_len(input rate_e r);
        return {1'b0, last_phase(r)} + 4'd1;
    endfunction

endpackage

// File: rtl/txhw_sync_detect.sv
// Sync event detector.
// Applies the selected polarity to the sync line and flags the cycle in
// which the line turns from inactive to active. Assumes sync_in is already
// synchronous to clk. The history register resets to "active", so a line
// held active across reset release does not create an event.
module txhw_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic sync_inv,
    output logic sync_edge
);

    logic sync_act;
    logic prev_q;

    // Normalise the polarity so that 1 always means active.
    always_comb begin
        sync_act  = sync_in ^ sync_inv;
        sync_edge = sync_act & ~prev_q;
    end

    // Remember last cycle's normalised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sync_act;
        end
    end

endmodule

// File: rtl/txhw_bit_timer.sv
// Bit cell and frame position timer.
// Keeps the cycle phase inside the current bit cell and the frame bit
// position. A sync event forces phase 0 and position (0 - offset) in the
// same cycle. One sample strobe is raised per cell, at the midpoint phase.
// Assumes the frame length is a power of two, so the position wraps
// naturally. Sampling starts only after the first sync event. frame_end
// marks the sample of the last frame bit, but only when bit 0 of the same
// frame was sampled after the most recent sync event.
module txhw_bit_timer
    import txhw_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_edge,
    input  rate_e            rate,
    input  logic [POS_W-1:0] offset,
    output logic             sample_stb,
    output logic [POS_W-1:0] bit_pos,
    output logic             frame_end
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] cur_phase;
    logic [PHASE_W-1:0] lastp;
    logic [PHASE_W-1:0] midp;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   cur_pos;
    logic               aligned_q;
    logic               started_q;
    logic               started_eff;

    // Effective position of this cycle; a sync event overrides the counters.
    always_comb begin
        lastp       = last_phase(rate);
        midp        = mid_phase(rate);
        cur_phase   = sync_edge ? '0 : phase_q;
        cur_pos     = sync_edge ? ({POS_W{1'b0}} - offset) : pos_q;
        started_eff = sync_edge ? 1'b0 : started_q;
        sample_stb  = (aligned_q | sync_edge) && (cur_phase == midp);
        bit_pos     = cur_pos;
        frame_end   = sample_stb && started_eff && (cur_pos == {POS_W{1'b1}});
    end

    // Advance the phase, and step the frame position at each cell boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            pos_q   <= '0;
        end else if (cur_phase >= lastp) begin
            phase_q <= '0;
            pos_q   <= cur_pos + POS_W'(1);
        end else begin
            phase_q <= cur_phase + PHASE_W'(1);
            pos_q   <= cur_pos;
        end
    end

    // Remember that a sync event has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned_q <= 1'b0;
        end else if (sync_edge) begin
            aligned_q <= 1'b1;
        end
    end

    // Track whether bit 0 was sampled since the last sync event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else if (sample_stb && (cur_pos == '0)) begin
            started_q <= 1'b1;
        end else begin
            started_q <= started_eff;
        end
    end

endmodule

// File: rtl/txhw_slot_select.sv
// Per-timeslot source selector.
// Builds one selection flag per timeslot from the global enable and the
// marker map, then routes either the signaling or the data input according
// to the flag of the timeslot now being sampled. Purely combinational.
module txhw_slot_select #(
    parameter int SLOTS      = 32,
    parameter int SLOT_IDX_W = 5
) (
    input  logic                  mux_en,
    input  logic [SLOTS-1:0]      slot_map,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic                  ser_data,
    input  logic                  ser_sig,
    output logic                  sel_bit
);

    logic [SLOTS-1:0] slot_use;

    // One selection flag per timeslot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_use[s] = mux_en & slot_map[s];
    end

    // Route the input chosen for the current timeslot.
    always_comb begin
        sel_bit = slot_use[slot_idx] ? ser_sig : ser_data;
    end

endmodule

// File: rtl/txhw_frame_asm.sv
// Frame assembler.
// Writes each sampled bit into a working frame register, with the bit
// order inside each timeslot reversed so that the first bit received lands
// in the timeslot's MSB. At frame end, the completed frame (including the
// bit sampled in that cycle) is copied to the output register and a
// one-cycle done strobe is raised. Assumes the slot width is a power of two.
module txhw_frame_asm #(
    parameter int FRAME_W   = 256,
    parameter int POS_W     = 8,
    parameter int BIT_IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [POS_W-1:0]   bit_pos,
    input  logic               sample_bit,
    input  logic               frame_end,
    output logic [FRAME_W-1:0] frame_out,
    output logic               frame_done
);

    logic [FRAME_W-1:0] asm_q;
    logic [FRAME_W-1:0] asm_next;
    logic [FRAME_W-1:0] out_q;
    logic               done_q;
    logic [POS_W-1:0]   wr_idx;

    // Map the frame position to its place in the output, MSB first per slot.
    always_comb begin
        wr_idx   = {bit_pos[POS_W-1:BIT_IDX_W], ~bit_pos[BIT_IDX_W-1:0]};
        asm_next = asm_q;
        if (sample_stb) begin
            asm_next[wr_idx] = sample_bit;
        end
    end

    // Hold the working frame, and publish it at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            asm_q  <= asm_next;
            done_q <= frame_end;
            if (frame_end) begin
                out_q <= asm_next;
            end
        end
    end

    assign frame_out  = out_q;
    assign frame_done = done_q;

endmodule

// File: rtl/txhw_slot_mux.sv
// Transmit highway slot multiplexer, top level.
// Aligns the frame to a sync event plus a bit offset, samples each bit
// cell at its midpoint, picks the source input per timeslot from a marker
// map, and presents each complete frame with a one-cycle done strobe.
// Assumes all inputs are synchronous to clk and that SLOTS and SLOT_W are
// powers of two.
module txhw_slot_mux
    import txhw_pkg::*;
#(
    parameter  int SLOTS      = 32,
    parameter  int SLOT_W     = 8,
    localparam int FRAME_W    = SLOTS * SLOT_W,
    localparam int POS_W      = $clog2(FRAME_W),
    localparam int SLOT_IDX_W = $clog2(SLOTS),
    localparam int BIT_IDX_W  = $clog2(SLOT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_in,
    input  logic               sync_inv,
    input  logic               ser_data,
    input  logic               ser_sig,
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic [POS_W-1:0]   bit_offset,
    input  logic               mux_en,
    input  logic [SLOTS-1:0]   slot_map,
    output logic [FRAME_W-1:0] frame_out,
    output logic               frame_done
);

    logic                  sync_edge;
    logic                  sample_stb;
    logic [POS_W-1:0]      bit_pos;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic                  frame_end;
    logic                  sel_bit;

    assign slot_idx = bit_pos[POS_W-1:BIT_IDX_W];

    txhw_sync_detect u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sync_inv  (sync_inv),
        .sync_edge (sync_edge)
    );

    txhw_bit_timer #(
        .POS_W (POS_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_edge  (sync_edge),
        .rate       (rate_e'(rate_sel)),
        .offset     (bit_offset),
        .sample_stb (sample_stb),
        .bit_pos    (bit_pos),
        .frame_end  (frame_end)
    );

    txhw_slot_select #(
        .SLOTS      (SLOTS),
        .SLOT_IDX_W (SLOT_IDX_W)
    ) u_select (
        .mux_en   (mux_en),
        .slot_map (slot_map),
        .slot_idx (slot_idx),
        .ser_data (ser_data),
        .ser_sig  (ser_sig),
        .sel_bit  (sel_bit)
    );

    txhw_frame_asm #(
        .FRAME_W   (FRAME_W),
        .POS_W     (POS_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .bit_pos    (bit_pos),
        .sample_bit (sel_bit),
        .frame_end  (frame_end),
        .frame_out  (frame_out),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/txhw_slot_mux_chk.sv
// Property checker for the transmit highway slot multiplexer, bound to
// every instance of the top module. It watches the ports and the internal
// nets that link the timer, the selector and the assembler. It keeps its
// own count of cycles between sample strobes.
module txhw_slot_mux_chk
    import txhw_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int FRAME_W    = 256,
    parameter int SLOT_IDX_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [RATE_W-1:0]     rate_sel,
    input logic                  mux_en,
    input logic [SLOTS-1:0]      slot_map,
    input logic                  ser_data,
    input logic                  ser_sig,
    input logic                  sync_edge,
    input logic                  sample_stb,
    input logic [SLOT_IDX_W-1:0] slot_idx,
    input logic                  sel_bit,
    input logic                  frame_done,
    input logic [FRAME_W-1:0]    frame_out
);

    logic [4:0]        gap_q;
    logic              gap_ok_q;
    logic [RATE_W-1:0] rate_q;
    logic [4:0]        want_gap;

    // Expected spacing between strobes for the current rate.
    always_comb begin
        want_gap = {1'b0, cell_len(rate_e'(rate_sel))};
    end

    // Count the cycles since the last strobe; invalidate on rate change or sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q    <= '0;
            gap_ok_q <= 1'b0;
            rate_q   <= '0;
        end else begin
            rate_q <= rate_sel;
            if (sample_stb) begin
                gap_q <= 5'd1;
            end else if (gap_q != 5'd31) begin
                gap_q <= gap_q + 5'd1;
            end
            if (rate_sel != rate_q) begin
                gap_ok_q <= 1'b0;
            end else if (sample_stb) begin
                gap_ok_q <= 1'b1;
            end else if (sync_edge) begin
                gap_ok_q <= 1'b0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(frame_out)); // R9

    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(sample_stb)); // R9

    AST_CELL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && gap_ok_q && !sync_edge && (rate_sel == rate_q)) |-> (gap_q == want_gap)); // R4

    AST_MARK_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && mux_en && slot_map[slot_idx]) |-> (sel_bit == ser_sig)); // R5

    AST_MARK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && mux_en && !slot_map[slot_idx]) |-> (sel_bit == ser_data)); // R6

    AST_MUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !mux_en) |-> (sel_bit == ser_data)); // R7

endmodule

bind txhw_slot_mux txhw_slot_mux_chk #(
    .SLOTS      (SLOTS),
    .FRAME_W    (FRAME_W),
    .SLOT_IDX_W (SLOT_IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .mux_en     (mux_en),
    .slot_map   (slot_map),
    .ser_data   (ser_data),
    .ser_sig    (ser_sig),
    .sync_edge  (sync_edge),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx),
    .sel_bit    (sel_bit),
    .frame_done (frame_done),
    .frame_out  (frame_out)
);

// File: tb/sim_txhw_slot_mux.sv
// Self-checking bench for txhw_slot_mux: a table of frame vectors walked by
// one loop, then directed reset, no-sync, resync and reset-mid-run tests.
module sim_txhw_slot_mux;

    localparam int WD_LIMIT = 190000;

    typedef struct packed {
        logic [1:0]  rate;
        logic [7:0]  off;
        logic        en;
        logic        inv;
        logic [1:0]  hold;
        logic [31:0] map;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'd0,   1'b1, 1'b0, 2'd1, 32'hA5C3_0F81, 8'h13},
        '{2'd1, 8'd17,  1'b1, 1'b1, 2'd1, 32'h8000_0001, 8'h02},
        '{2'd2, 8'd255, 1'b1, 1'b0, 2'd3, 32'h5555_AAAA, 8'h07},
        '{2'd3, 8'd1,   1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF, 8'h09},
        '{2'd3, 8'd128, 1'b1, 1'b1, 2'd2, 32'h0F0F_F0F0, 8'h04},
        '{2'd0, 8'd255, 1'b1, 1'b1, 2'd1, 32'h0000_0000, 8'h15},
        '{2'd1, 8'd3,   1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, 8'h05}
    };

    localparam string VTAG [NVEC] = '{
        "R5 R6 R8 offset 0",
        "R2 active-low R5 R6",
        "R11 offset 255 R2 held sync",
        "R7 mux off map ignored",
        "R2 active-low held R5 R6",
        "R6 R11 all markers low",
        "R5 all markers high"
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_in = 1'b0;
    logic         sync_inv = 1'b0;
    logic         ser_data = 1'b0;
    logic         ser_sig = 1'b0;
    logic [1:0]   rate_sel = 2'd0;
    logic [7:0]   bit_offset = 8'd0;
    logic         mux_en = 1'b0;
    logic [31:0]  slot_map = 32'd0;
    logic [255:0] frame_out;
    logic         frame_done;

    int           cyc = 0;
    int           total = 0;
    int           bad = 0;
    int           done_cnt = 0;
    int           done_cyc = 0;
    logic [255:0] got_frame = '0;

    txhw_slot_mux u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .sync_inv   (sync_inv),
        .ser_data   (ser_data),
        .ser_sig    (ser_sig),
        .rate_sel   (rate_sel),
        .bit_offset (bit_offset),
        .mux_en     (mux_en),
        .slot_map   (slot_map),
        .frame_out  (frame_out),
        .frame_done (frame_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record each done strobe, sampled away from the active edge.
    always @(negedge clk) begin
        if (frame_done) begin
            done_cnt  = done_cnt + 1;
            done_cyc  = cyc;
            got_frame = frame_out;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog R9 act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic dat_bit(input logic [7:0] seed, input int p);
        logic [7:0] h;
        h = 8'(p * 29) ^ seed ^ 8'(p >> 3);
        return h[2] ^ h[5] ^ h[7];
    endfunction

    function automatic logic sig_bit(input logic [7:0] seed, input int p);
        logic [7:0] h;
        h = 8'(p * 53) + 8'(seed * 3) + 8'(p >> 2);
        return h[1] ^ h[4] ^ ~h[6];
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Configure, send one sync event and one full frame, then check it.
    task automatic run_frame(input int rate, input int off, input bit en,
                             input bit inv, input int hold,
                             input logic [31:0] map, input logic [7:0] seed,
                             input string tag);
        int           cpb;
        int           mid;
        int           k;
        int           base;
        int           exp_cyc;
        logic [255:0] exp;
        cpb = 1 << rate;
        mid = cpb / 2;
        k   = 0;
        rate_sel   = 2'(rate);
        bit_offset = 8'(off);
        mux_en     = en;
        slot_map   = map;
        sync_inv   = inv;
        sync_in    = inv;
        @(posedge clk);
        @(negedge clk);
        base = done_cnt;
        for (int c = 0; c < off + 256; c++) begin
            int   p = (c + 256 - off) % 256;
            logic d = dat_bit(seed, p);
            logic s = sig_bit(seed, p);
            for (int j = 0; j < cpb; j++) begin
                sync_in  = ((c * cpb + j) < hold) ? ~inv : inv;
                ser_data = (j == mid) ? d : ~d;
                ser_sig  = (j == mid) ? s : ~s;
                @(posedge clk);
                if (c == 0 && j == 0) begin
                    #1;
                    k = cyc;
                end
                @(negedge clk);
            end
        end
        sync_in = inv;
        repeat (3) @(negedge clk);
        for (int ts = 0; ts < 32; ts++) begin
            for (int b = 0; b < 8; b++) begin
                int p = 8 * ts + b;
                exp[8 * ts + 7 - b] = (en && map[ts]) ? sig_bit(seed, p) : dat_bit(seed, p);
            end
        end
        exp_cyc = k + (off + 255) * cpb + mid;
        chk(done_cnt - base == 1, $sformatf("R9 R10 strobe count [%s]", tag),
            256'(done_cnt - base), 256'(1));
        chk(done_cyc == exp_cyc, $sformatf("R3 R4 R2 strobe cycle [%s]", tag),
            256'(done_cyc), 256'(exp_cyc));
        chk(got_frame == exp, $sformatf("R8 frame content [%s]", tag),
            got_frame, exp);
    endtask

    // Run cycles with toggling inputs and no sync event.
    task automatic idle_run(input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = i[0];
            ser_sig  = i[1];
            @(negedge clk);
        end
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(frame_out == '0, "R1 frame_out under reset", frame_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_out == '0, "R1 frame_out after reset", frame_out, '0);
        chk(frame_done == 1'b0, "R1 frame_done after reset", 256'(frame_done), '0);

        // R1: no frame without a sync event.
        base = done_cnt;
        idle_run(600);
        chk(done_cnt == base, "R1 no strobe before sync", 256'(done_cnt - base), '0);

        for (int v = 0; v < NVEC; v++) begin
            run_frame(int'(VECS[v].rate), int'(VECS[v].off), VECS[v].en,
                      VECS[v].inv, int'(VECS[v].hold), VECS[v].map,
                      VECS[v].seed, VTAG[v]);
        end

        // R10: sync, 200 cells, then resync with offset 60 aborts the old frame.
        rate_sel   = 2'd0;
        bit_offset = 8'd0;
        mux_en     = 1'b1;
        slot_map   = 32'h1234_5678;
        sync_inv   = 1'b0;
        sync_in    = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 200; c++) begin
            sync_in  = (c == 0);
            ser_data = dat_bit(8'h77, c);
            ser_sig  = sig_bit(8'h77, c);
            @(negedge clk);
        end
        sync_in = 1'b0;
        run_frame(0, 60, 1'b1, 1'b0, 1, 32'h1234_5678, 8'h31, "R10 resync mid-frame");

        // R1: reset mid-run clears the output and needs a new sync.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(frame_out == '0, "R1 frame_out after later reset", frame_out, '0);
        rst_n = 1'b1;
        base = done_cnt;
        idle_run(600);
        chk(done_cnt == base, "R1 no strobe after reset without sync",
            256'(done_cnt - base), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule